// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Tracker

This block holds the replacement state for one set of an eight-way set-associative cache. It uses a binary tree of single-bit steering flags, one flag for each internal node. Decoding the flags gives the way that has gone unused longest in the pseudo-LRU sense. The cache controller offers that way as the victim when it needs to fill the set.

When the controller reports a hit or a fill, it pulses the access strobe and gives the way it touched. On the next rising edge the tracker rewrites the flags along that way's path so that every flag on the path points away from it. Flags off the path keep their values.

The flags are stored in in-order (horizontal) tree layout. The root sits at the middle bit, the two mid-level nodes sit at bits 1 and 5, and the leaf-level nodes sit at the even positions. Each update value is assembled by bit position, never in traversal order.

Top module: `plru_tracker`

## Requirements
- R1: A synchronous reset clears all seven flags to 0, so the victim output is way 0 in the first cycle after reset.
- R2: The victim search starts at the root flag at bit 3. A flag value of 0 steers the search to the left (lower-numbered) subtree and a value of 1 steers it to the right. With bit 3 = 1, bit 5 = 0 and bit 4 = 1 the victim is way 5.
- R3: The flag positions follow the in-order layout. Bit 1 steers between ways 0–1 and 2–3, and bit 5 steers between ways 4–5 and 6–7. Bits 0, 2, 4 and 6 steer between ways 0/1, 2/3, 4/5 and 6/7. The victim decode matches this layout for every one of the 128 flag patterns.
- R4: An access writes each flag on the touched way's root-to-leaf path with the value that points away from that way. All other flags keep their values, so at most three flags change per access.
- R5: Right after any access, the victim output differs from the way just touched.
- R6: When the access strobe is low, the flags and the victim output do not change, whatever the way input carries.
- R7: The victim output is a combinational decode of the registered flags. It reflects an access in the cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access or fill strobe for the touched way |
| acc_way | input | 3 | Index of the touched way |
| victim_way | output | 3 | Current pseudo-LRU victim way |

## Verification
The embedded properties assume that reset is asserted on the first clock edge and that the way index is a known value whenever the strobe is high. The bench holds reset for the opening cycles and always drives a defined index. It also changes the index on idle cycles, so that the hold rule is exercised against a live input. Random access and idle cycles are mixed until the bench's own model has visited all 128 flag patterns. A directed sequence reaches the way-5 example.

// File: rtl/plru_pkg.sv
package plru_pkg;

   // Bit position of tree node (level, pos) in in-order layout for a tree of
   // 'depth' levels: level 0 is the root, pos counts left to right.
   function automatic int node_bit(input int level, input int pos, input int depth);
      return ((2 * pos + 1) << (depth - 1 - level)) - 1;
   endfunction

endpackage

// File: rtl/plru_victim_walk.sv
module plru_victim_walk
   import plru_pkg::*;
#(
   parameter int WAYS = 8,
   localparam int LEVELS = $clog2(WAYS),
   localparam int NODES  = WAYS - 1
) (
   input  logic [NODES-1:0]  flags,
   output logic [LEVELS-1:0] victim
);

   always_comb begin
      int pos;
      pos = 0;
      for (int lvl = 0; lvl < LEVELS; lvl++) begin
         pos = (pos << 1) | int'(flags[node_bit(lvl, pos, LEVELS)]);
      end
      victim = LEVELS'(pos);
   end

endmodule

// File: rtl/plru_path_update.sv
module plru_path_update
   import plru_pkg::*;
#(
   parameter int WAYS = 8,
   localparam int LEVELS = $clog2(WAYS),
   localparam int NODES  = WAYS - 1
) (
   input  logic [NODES-1:0]  cur_flags,
   input  logic [LEVELS-1:0] way,
   output logic [NODES-1:0]  new_flags
);

   always_comb begin
      int pos;
      new_flags = cur_flags;
      for (int lvl = 0; lvl < LEVELS; lvl++) begin
         pos = int'(way) >> (LEVELS - lvl);
         // point away: way bit 1 (went right) -> flag 0 (steer left)
         new_flags[node_bit(lvl, pos, LEVELS)] = ~way[LEVELS-1-lvl];
      end
   end

endmodule

// File: rtl/plru_tracker.sv
module plru_tracker #(
   parameter int WAYS = 8,
   localparam int LEVELS = $clog2(WAYS),
   localparam int NODES  = WAYS - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_valid,
   input  logic [LEVELS-1:0] acc_way,
   output logic [LEVELS-1:0] victim_way
);

   generate
      if (WAYS < 2 || (1 << LEVELS) != WAYS) begin : g_bad_ways
         $error("plru_tracker: WAYS must be a power of two of at least 2");
      end
   endgenerate

   logic [NODES-1:0] flags_q;
   logic [NODES-1:0] flags_next;

   plru_path_update #(.WAYS(WAYS)) u_update (
      .cur_flags (flags_q),
      .way       (acc_way),
      .new_flags (flags_next)
   );

   always_ff @(posedge clk) begin
      if (rst)            flags_q <= '0;
      else if (acc_valid) flags_q <= flags_next;
   end

   plru_victim_walk #(.WAYS(WAYS)) u_walk (
      .flags  (flags_q),
      .victim (victim_way)
   );

   // R1: reset leaves way 0 as the victim
   p_reset_victim_r1: assert property (@(posedge clk)
      rst |=> victim_way == '0);

   // R5: a touched way is never the immediate next victim
   p_touched_not_victim_r5: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> victim_way != $past(acc_way));

   // R6: idle cycles hold the replacement state
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !acc_valid |=> $stable(flags_q) && $stable(victim_way));

   // R4: an access rewrites no more than one flag per tree level
   p_path_only_r4: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> $countones(flags_q ^ $past(flags_q)) <= LEVELS);

endmodule

// File: tb/plru_tracker_test.sv
module plru_tracker_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       acc_valid = 1'b0;
   logic [2:0] acc_way = 3'd0;
   logic [2:0] victim_way;

   int checks = 0;
   int fails  = 0;
   int model_flags = 0;
   bit seen [128];

   always #5 clk = ~clk;

   plru_tracker uut (
      .clk        (clk),
      .rst        (rst),
      .acc_valid  (acc_valid),
      .acc_way    (acc_way),
      .victim_way (victim_way)
   );

   // Reference: range-halving walk; node of range [lo,hi) sits at bit (lo+hi)/2-1
   function automatic int ref_victim(input int f);
      int lo = 0, hi = 8, mid;
      while (hi - lo > 1) begin
         mid = (lo + hi) / 2;
         if (f[mid - 1]) lo = mid; else hi = mid;
      end
      return lo;
   endfunction

   function automatic int ref_touch(input int f, input int w);
      int lo = 0, hi = 8, mid;
      while (hi - lo > 1) begin
         mid = (lo + hi) / 2;
         if (w < mid) begin f[mid - 1] = 1'b1; hi = mid; end
         else         begin f[mid - 1] = 1'b0; lo = mid; end
      end
      return f;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, model updates with the edge, compare at next negedge
   task automatic step(input bit v, input int w);
      int prev_victim;
      prev_victim = victim_way;
      acc_valid = v;
      acc_way   = 3'(w);
      @(posedge clk);
      if (v) model_flags = ref_touch(model_flags, w);
      seen[model_flags] = 1'b1;
      @(negedge clk);
      check("R2/R7 victim vs model", victim_way, ref_victim(model_flags));
      if (v) begin
         checks++;
         if (victim_way == 3'(w)) begin
            fails++;
            $display("FAIL R5: actual victim %0d expected anything but %0d", victim_way, w);
         end
      end else begin
         check("R6 idle hold", victim_way, prev_victim);
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 reset victim", victim_way, 0);
      seen[0] = 1'b1;

      // R2: reach bit3=1, bit5=0, bit4=1 -> way 5
      step(1'b1, 4);
      step(1'b1, 6);
      step(1'b1, 0);
      check("R2 example way 5", victim_way, 5);

      // R4/R7: touching all ways in order returns victim to way 0
      for (int w = 0; w < 8; w++) step(1'b1, w);
      check("R4 sweep back to way 0", victim_way, 0);

      // R6: idle with changing way index
      for (int w = 0; w < 8; w++) step(1'b0, 7 - w);

      // random mix until coverage of all patterns
      for (int i = 0; i < 20000; i++) begin
         step(($urandom % 4) != 0, int'($urandom % 8));
      end

      begin
         int n = 0;
         for (int p = 0; p < 128; p++) if (seen[p]) n++;
         check("R3 all 128 flag patterns decoded", n, 128);
      end

      // R1: reset mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_flags = 0;
      check("R1 reset mid-run", victim_way, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule